// File: doc/BRIEF.md
# Shared-Timer GPIO Input Debouncer

This block cleans up a group of general-purpose input pins, arranged as several 8-bit banks. Every pin runs through a two-flop synchronizer and then through its own glitch filter. The filter's hold time does not live in the pin. Instead, each pin picks one of three cycle-count timers that all pins share, or it picks no filtering at all. A filtered pin moves to a new level only once the synchronized input has kept that level long enough.

Software programs the block through a small register port. The port has a byte address, separate write and read strobes, and read data that appears one cycle after the read strobe. Each pin's 2-bit mode code is split across two selection registers. The register at 0x00 holds the high bit of the code, and the register at 0x04 holds the low bit. In both registers the pin uses the bit whose position equals its pin number. The three period registers sit at 0x50, 0x54 and 0x58. Software normally updates a single pin's mode with a read-modify-write, so every register reads back exactly what was stored.

Top module: `gpio_shared_debounce`

## Requirements
- R1: While reset is asserted, every filtered output is 0. After reset, every mapped register reads 0.
- R2: The registers map as follows: the high code bit of pin i is bit i at 0x00, and the low code bit of pin i is bit i at 0x04. The periods of timers 1, 2 and 3 are at 0x50, 0x54 and 0x58. A read returns the stored 32-bit value on `reg_rdata` in the cycle after `reg_rd` is sampled.
- R3: An address that is not exactly one of the five mapped addresses reads as 0, and a write to it changes no register. Unaligned addresses count as unmapped.
- R4: A pin with code 0 follows its raw input with no filtering. A raw change made between two clock edges appears at the output after the third rising edge.
- R5: A pin with code 1, 2 or 3 uses the period P of timer 1, 2 or 3. Its output takes the new level only after the synchronized input has differed from the output on P+1 consecutive edges. A raw change therefore reaches the output after edge P+3.
- R6: If the synchronized input returns to the current output level while a pin is counting, the count restarts from zero.
- R7: A period of 0 gives a one-cycle filter, with the same latency as code 0.
- R8: If software writes the period register of a pin's selected timer, or changes a pin's code, while that pin is counting, the count restarts.
- R9: The code bit from 0x00 is the more significant bit. A pin with only its 0x00 bit set uses timer 2 (0x54), not timer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 32 | Raw asynchronous pin levels |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_clean | output | 32 | Filtered pin levels |

## Verification
The hardest cases to reach from the ports are the count restarts in the middle of a count. These happen when a period is rewritten or a code changes partway through a count, or when the input bounces back for a single cycle. The bench makes each one happen at a known edge, a few cycles after a raw change. It then checks that the output has still not moved on the edge where an unrestarted count would already have switched, and that it does move exactly P+1 edges after the restart. The test periods are chosen so that picking the wrong timer, or swapping the two code bits, moves the edge where the output changes.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
   localparam int CODE_W  = 2;
   localparam int NUM_TMR = 3;

   localparam logic [7:0] OFS_SEL_HI   = 8'h00;
   localparam logic [7:0] OFS_SEL_LO   = 8'h04;
   localparam logic [7:0] OFS_TMR0     = 8'h50;
   localparam logic [7:0] OFS_TMR_STEP = 8'h04;

   typedef logic [CODE_W-1:0] dbn_code_t;

   function automatic logic [7:0] tmr_ofs(input int idx);
      return OFS_TMR0 + OFS_TMR_STEP * 8'(idx);
   endfunction
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gdb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            chain_q[k] <= chain_q[k-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gdb_regs.sv
module gdb_regs
   import gdb_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int TMR_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                wdata,
   input  logic                            wr,
   input  logic                            rd,
   output logic [REG_W-1:0]                rdata,
   output logic [REG_W-1:0]                sel_hi,
   output logic [REG_W-1:0]                sel_lo,
   output logic [NUM_TMR-1:0][TMR_W-1:0]   periods,
   output logic [NUM_TMR-1:0]              tmr_wr
);
   if (TMR_W > REG_W) begin : g_bad_tmr_w
      $error("gdb_regs: TMR_W must not exceed REG_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("gdb_regs: ADDR_W must be at least 8");
   end

   logic                          hit_hi, hit_lo, any_hit;
   logic [NUM_TMR-1:0]            hit_tmr;
   logic [REG_W-1:0]              sel_hi_q, sel_lo_q, rd_val, rdata_q;
   logic [NUM_TMR-1:0][TMR_W-1:0] tmr_q;

   assign hit_hi  = (addr == ADDR_W'(OFS_SEL_HI));
   assign hit_lo  = (addr == ADDR_W'(OFS_SEL_LO));
   assign any_hit = hit_hi | hit_lo | (|hit_tmr);

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_hi_q <= '0;
         sel_lo_q <= '0;
      end else if (wr) begin
         if (hit_hi) sel_hi_q <= wdata;
         if (hit_lo) sel_lo_q <= wdata;
      end
   end

   for (genvar j = 0; j < NUM_TMR; j++) begin : g_tmr
      assign hit_tmr[j] = (addr == ADDR_W'(tmr_ofs(j)));
      assign tmr_wr[j]  = wr & hit_tmr[j];

      always_ff @(posedge clk) begin
         if (rst)            tmr_q[j] <= '0;
         else if (tmr_wr[j]) tmr_q[j] <= wdata[TMR_W-1:0];
      end
   end

   always_comb begin
      rd_val = '0;
      if (hit_hi) rd_val = sel_hi_q;
      if (hit_lo) rd_val = sel_lo_q;
      for (int j = 0; j < NUM_TMR; j++) begin
         if (hit_tmr[j]) rd_val = REG_W'(tmr_q[j]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata_q <= '0;
      else if (rd) rdata_q <= rd_val;
   end

   assign rdata   = rdata_q;
   assign sel_hi  = sel_hi_q;
   assign sel_lo  = sel_lo_q;
   assign periods = tmr_q;

   // R3
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && !any_hit) |=> ($stable(sel_hi_q) && $stable(sel_lo_q) && $stable(tmr_q)));

   // R2
   tmr_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd && addr == ADDR_W'(OFS_TMR0)) |=> (rdata == REG_W'($past(tmr_q[0]))));
endmodule

// File: rtl/gdb_filter.sv
module gdb_filter
   import gdb_pkg::*;
#(
   parameter int TMR_W = 32
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          s,
   input  dbn_code_t                     code,
   input  logic [NUM_TMR-1:0][TMR_W-1:0] periods,
   input  logic [NUM_TMR-1:0]            tmr_wr,
   output logic                          dout
);
   logic             held_q;
   logic [TMR_W-1:0] cnt_q;
   dbn_code_t        code_q;
   logic [TMR_W-1:0] per;
   logic             restart;

   always_comb begin
      per     = '0;
      restart = 1'b0;
      for (int j = 0; j < NUM_TMR; j++) begin
         if (code == dbn_code_t'(j + 1)) begin
            per     = periods[j];
            restart = tmr_wr[j];
         end
      end
      if (code != code_q) restart = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= 1'b0;
         cnt_q  <= '0;
         code_q <= '0;
      end else begin
         code_q <= code;
         if (code == '0) begin
            held_q <= s;
            cnt_q  <= '0;
         end else if (restart || s == held_q) begin
            cnt_q <= '0;
         end else if (cnt_q >= per) begin
            held_q <= s;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + TMR_W'(1);
         end
      end
   end

   assign dout = held_q;

   // R4
   off_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (code == '0) |=> (held_q == $past(s)));

   // R5
   change_src_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(held_q) |-> (held_q == $past(s)));

   // R6
   hold_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (code != '0 && s == held_q) |=> (cnt_q == '0));
endmodule

// File: rtl/gpio_shared_debounce.sv
module gpio_shared_debounce
   import gdb_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int BANK_W      = 8,
   parameter int REG_W       = 32,
   parameter int TMR_W       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_BANKS*BANK_W-1:0] pin_raw,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [REG_W-1:0]            reg_wdata,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   output logic [REG_W-1:0]            reg_rdata,
   output logic [NUM_BANKS*BANK_W-1:0] pin_clean
);
   localparam int NPIN = NUM_BANKS * BANK_W;

   if (NPIN != REG_W) begin : g_bad_pins
      $error("gpio_shared_debounce: NUM_BANKS*BANK_W must equal REG_W");
   end

   logic [NPIN-1:0]               pin_s;
   logic [REG_W-1:0]              sel_hi, sel_lo;
   logic [NUM_TMR-1:0][TMR_W-1:0] periods;
   logic [NUM_TMR-1:0]            tmr_wr;

   gdb_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_raw),
      .q   (pin_s)
   );

   gdb_regs #(.REG_W(REG_W), .TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .wr      (reg_wr),
      .rd      (reg_rd),
      .rdata   (reg_rdata),
      .sel_hi  (sel_hi),
      .sel_lo  (sel_lo),
      .periods (periods),
      .tmr_wr  (tmr_wr)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      gdb_filter #(.TMR_W(TMR_W)) u_filt (
         .clk     (clk),
         .rst     (rst),
         .s       (pin_s[i]),
         .code    ({sel_hi[i], sel_lo[i]}),
         .periods (periods),
         .tmr_wr  (tmr_wr),
         .dout    (pin_clean[i])
      );
   end

   // R1
   rst_clean_chk: assert property (@(posedge clk)
      rst |=> (pin_clean == '0 && reg_rdata == '0));
endmodule

// File: tb/gpio_shared_debounce_test.sv
module gpio_shared_debounce_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pin_raw = 32'h0000_00F0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic [31:0] pin_clean;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   gpio_shared_debounce uut (
      .clk       (clk),
      .rst       (rst),
      .pin_raw   (pin_raw),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .pin_clean (pin_clean)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic [7:0]  wa;
      logic [31:0] wd;
      logic [7:0]  ra;
      logic [31:0] ex;
   } vec_t;

   // R2 mapped write/readback, R3 unmapped and unaligned addresses
   localparam vec_t VEC [0:9] = '{
      '{8'h50, 32'h0000_0005, 8'h50, 32'h0000_0005},
      '{8'h54, 32'hDEAD_BEEF, 8'h54, 32'hDEAD_BEEF},
      '{8'h58, 32'h1234_5678, 8'h58, 32'h1234_5678},
      '{8'h00, 32'hA5A5_0F0F, 8'h00, 32'hA5A5_0F0F},
      '{8'h04, 32'h5A5A_F0F0, 8'h04, 32'h5A5A_F0F0},
      '{8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_0000},
      '{8'h5C, 32'hFFFF_FFFF, 8'h5C, 32'h0000_0000},
      '{8'h52, 32'hFFFF_FFFF, 8'h50, 32'h0000_0005},
      '{8'h03, 32'h0000_0000, 8'h00, 32'hA5A5_0F0F},
      '{8'hFC, 32'h0000_0001, 8'h54, 32'hDEAD_BEEF}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick();
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      reg_addr = a;
      reg_rd   = 1'b1;
      tick();
      reg_rd   = 1'b0;
      v        = reg_rdata;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) tick();
      chk("R1 outputs low in reset", pin_clean, 32'h0);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      @(negedge clk);
      do_reset();
      rd(8'h00, v); chk("R1 sel hi after reset", v, 32'h0);
      rd(8'h04, v); chk("R1 sel lo after reset", v, 32'h0);
      rd(8'h50, v); chk("R1 timer1 after reset", v, 32'h0);
      rd(8'h58, v); chk("R1 timer3 after reset", v, 32'h0);
      chk("R4 code 0 follows input", pin_clean, 32'h0000_00F0);

      for (int n = 0; n < 10; n++) begin
         wr(VEC[n].wa, VEC[n].wd);
         rd(VEC[n].ra, v);
         chk($sformatf("R2/R3 vector %0d", n), v, VEC[n].ex);
      end

      pin_raw = 32'h0;
      do_reset();
      rd(8'h54, v); chk("R1 timer2 cleared by reset", v, 32'h0);
      rd(8'h00, v); chk("R1 sel hi cleared by reset", v, 32'h0);

      // pin1 code1 (P=5), pin2 code2 (P=9), pin3 code3 (P=0)
      wr(8'h50, 32'd5);
      wr(8'h54, 32'd9);
      wr(8'h58, 32'd0);
      wr(8'h00, 32'h0000_000C);
      wr(8'h04, 32'h0000_000A);

      // R4: code 0 latency of three edges
      pin_raw[0] = 1'b1;
      repeat (2) tick();
      chk("R4 pin0 before third edge", {31'b0, pin_clean[0]}, 32'd0);
      tick();
      chk("R4 pin0 after third edge", {31'b0, pin_clean[0]}, 32'd1);

      // R5, R7, R9
      pin_raw[3:1] = 3'b111;
      repeat (2) tick();
      chk("R7 pin3 period0 before edge3", {31'b0, pin_clean[3]}, 32'd0);
      chk("R5 pin1 held early", {31'b0, pin_clean[1]}, 32'd0);
      tick();
      chk("R7 pin3 period0 at edge3", {31'b0, pin_clean[3]}, 32'd1);
      repeat (4) tick();
      chk("R5 pin1 before edge P+3", {31'b0, pin_clean[1]}, 32'd0);
      tick();
      chk("R5 pin1 at edge P+3", {31'b0, pin_clean[1]}, 32'd1);
      chk("R9 pin2 uses timer2 not timer1", {31'b0, pin_clean[2]}, 32'd0);
      repeat (3) tick();
      chk("R9 pin2 before edge 12", {31'b0, pin_clean[2]}, 32'd0);
      tick();
      chk("R9 pin2 at edge 12", {31'b0, pin_clean[2]}, 32'd1);

      // R6: one-cycle bounce back restarts the count
      pin_raw[1] = 1'b0;
      repeat (4) tick();
      pin_raw[1] = 1'b1;
      tick();
      pin_raw[1] = 1'b0;
      repeat (7) tick();
      chk("R6 pin1 held after bounce", {31'b0, pin_clean[1]}, 32'd1);
      tick();
      chk("R6 pin1 changes after restarted count", {31'b0, pin_clean[1]}, 32'd0);

      // R8: timer rewrite restarts the count
      pin_raw[1] = 1'b1;
      repeat (4) tick();
      wr(8'h50, 32'd5);
      repeat (5) tick();
      chk("R8 timer write restart held", {31'b0, pin_clean[1]}, 32'd0);
      tick();
      chk("R8 timer write restart release", {31'b0, pin_clean[1]}, 32'd1);

      // R8: code change restarts the count (pin1 code1 -> code3, P=7)
      wr(8'h58, 32'd7);
      pin_raw[1] = 1'b0;
      repeat (4) tick();
      wr(8'h00, 32'h0000_000E);
      repeat (8) tick();
      chk("R8 code change restart held", {31'b0, pin_clean[1]}, 32'd1);
      tick();
      chk("R8 code change restart release", {31'b0, pin_clean[1]}, 32'd0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule